// File: doc/BRIEF.md
# Colour Subcarrier Phase Oscillator

This block is a numerically controlled oscillator that produces the colour subcarrier phase for a video encoder clocked at 27 MHz. On every clock a 32-bit phase accumulator advances by a programmable frequency increment. The increment equals the number of subcarrier cycles in one video line divided by the number of clocks in that line, scaled by 2^32 and rounded to the nearest integer. For a 525-line system, 227.5 cycles over 1716 clocks gives 0x21F07C1F.

Software writes the increment one byte at a time over a plain address/data/write-enable port. The three low bytes go into a shadow store. Writing the top byte moves the whole 32-bit value into the active increment in one step, so the accumulator never runs on a half-updated value. A separate 8-bit phase offset register rotates the output phase in steps of 360/256 degrees (about 1.41°). The block adds that offset to the most significant byte of the accumulator value and presents the top 10 bits of the sum, registered, to a later sine lookup.

The output is a free-running sample stream with one new phase value on every clock. It has no valid/ready handshake and no back-pressure. Stalling the stream would change the subcarrier frequency, so a consumer must take one sample on every clock. The register port is a plain control port.

Top module: `subcarrier_nco`

## Requirements
- R1: While `rst` is high at a clock edge, the accumulator and `phase_out` become 0 after that edge.
- R2: Register address 0x09 holds increment bits 7:0, 0x0A holds bits 15:8, 0x0B holds bits 23:16 and 0x0C holds bits 31:24 (little-endian byte order).
- R3: Writes to 0x09, 0x0A and 0x0B change only the shadow bytes. The running frequency does not change until 0x0C is written. That write loads {written byte, shadow bytes} into the active increment at the same edge.
- R4: Every clock out of reset, the accumulator adds the active increment, modulo 2^32.
- R5: Address 0x0D holds the 8-bit phase offset. Its value is added to bits 31:24 of the accumulator value, and the sum wraps modulo 2^32.
- R6: `phase_out` is bits 31:22 of (accumulator + offset·2^24), registered, so it lags the accumulator by exactly one clock.
- R7: After reset the active increment is 0x00000016 (shadow byte 0 = 0x16, other bytes 0) and the phase offset is 0x00.
- R8: Writes to any address other than 0x09 to 0x0D have no effect on the increment, the offset or the output.
- R9: With increment 0x21F07C1F, 1716 clocks advance `phase_out` by 511 or 512 codes modulo 1024 (half a cycle).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register address |
| cfg_data | input | 8 | Register write data |
| phase_out | output | 10 | Registered subcarrier phase, top 10 bits |

## Verification
The assertions check on every cycle that the accumulator steps by exactly the active increment and that `phase_out` follows the offset sum one clock later. They also check that low-byte writes leave the active increment unchanged, that a top-byte write lands in bits 31:24, and that stray addresses touch no register. The bench's sweeps cover what needs a longer history. These are the phase drift over a full 525-line video line, the complete range of 256 offset codes with and without wrap, and the staging of a new increment across separate byte writes. Only these scenarios show that the reset values take effect.

// File: rtl/sc_nco_pkg.sv
package sc_nco_pkg;
  localparam int unsigned DEF_ACC_W   = 32;
  localparam int unsigned DEF_OFF_W   = 8;
  localparam int unsigned DEF_OUT_W   = 10;
  localparam int unsigned DEF_ADDR_W  = 5;
  localparam int unsigned DEF_FREQ_BASE  = 9;
  localparam int unsigned DEF_PHASE_ADDR = 13;
  localparam logic [31:0] DEF_FREQ_RST   = 32'h0000_0016;
  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/sc_nco_regs.sv
module sc_nco_regs
  import sc_nco_pkg::*;
#(
  parameter int unsigned ACC_W      = DEF_ACC_W,
  parameter int unsigned OFF_W      = DEF_OFF_W,
  parameter int unsigned ADDR_W     = DEF_ADDR_W,
  parameter int unsigned FREQ_BASE  = DEF_FREQ_BASE,
  parameter int unsigned PHASE_ADDR = DEF_PHASE_ADDR,
  parameter logic [ACC_W-1:0] FREQ_RST = ACC_W'(DEF_FREQ_RST)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [ACC_W-1:0]  inc_active,
  output logic [OFF_W-1:0]  phase_off
);
  localparam int unsigned NBYTES = ACC_W / BYTE_W;
  localparam int unsigned LOW_W  = ACC_W - BYTE_W;
  localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(FREQ_BASE + NBYTES - 1);
  localparam logic [ADDR_W-1:0] OFF_ADDR = ADDR_W'(PHASE_ADDR);

  logic [LOW_W-1:0] shadow_flat;
  logic             top_hit;

  // shadow bytes for all but the most significant increment byte
  for (genvar b = 0; b < NBYTES - 1; b++) begin : g_shadow
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(FREQ_BASE + b);
    logic [BYTE_W-1:0] byte_q;
    always_ff @(posedge clk) begin
      if (rst)
        byte_q <= FREQ_RST[b*BYTE_W +: BYTE_W];
      else if (wr_en && wr_addr == MY_ADDR)
        byte_q <= wr_data;
    end
    assign shadow_flat[b*BYTE_W +: BYTE_W] = byte_q;
  end

  assign top_hit = wr_en && (wr_addr == TOP_ADDR);

  // the top-byte write commits the whole word at once
  always_ff @(posedge clk) begin
    if (rst)
      inc_active <= FREQ_RST;
    else if (top_hit)
      inc_active <= {wr_data, shadow_flat};
  end

  always_ff @(posedge clk) begin
    if (rst)
      phase_off <= '0;
    else if (wr_en && wr_addr == OFF_ADDR)
      phase_off <= wr_data[OFF_W-1:0];
  end
endmodule

// File: rtl/sc_nco_accum.sv
module sc_nco_accum #(
  parameter int unsigned ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] inc,
  output logic [ACC_W-1:0] acc
);
  always_ff @(posedge clk) begin
    if (rst)
      acc <= '0;
    else
      acc <= acc + inc;
  end
endmodule

// File: rtl/sc_nco_phase_out.sv
module sc_nco_phase_out #(
  parameter int unsigned ACC_W = 32,
  parameter int unsigned OFF_W = 8,
  parameter int unsigned OUT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] acc,
  input  logic [OFF_W-1:0] off,
  output logic [OUT_W-1:0] phase
);
  localparam int unsigned PAD_W = ACC_W - OFF_W;

  logic [ACC_W-1:0] rotated;

  assign rotated = acc + {off, {PAD_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (rst)
      phase <= '0;
    else
      phase <= rotated[ACC_W-1 -: OUT_W];
  end
endmodule

// File: rtl/subcarrier_nco.sv
module subcarrier_nco
  import sc_nco_pkg::*;
#(
  parameter int unsigned ACC_W      = DEF_ACC_W,
  parameter int unsigned OFF_W      = DEF_OFF_W,
  parameter int unsigned OUT_W      = DEF_OUT_W,
  parameter int unsigned ADDR_W     = DEF_ADDR_W,
  parameter int unsigned FREQ_BASE  = DEF_FREQ_BASE,
  parameter int unsigned PHASE_ADDR = DEF_PHASE_ADDR
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [7:0]        cfg_data,
  output logic [OUT_W-1:0]  phase_out
);
  logic [ACC_W-1:0] inc_active;
  logic [OFF_W-1:0] phase_off;
  logic [ACC_W-1:0] acc_q;

  sc_nco_regs #(
    .ACC_W(ACC_W), .OFF_W(OFF_W), .ADDR_W(ADDR_W),
    .FREQ_BASE(FREQ_BASE), .PHASE_ADDR(PHASE_ADDR),
    .FREQ_RST(ACC_W'(DEF_FREQ_RST))
  ) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(cfg_we), .wr_addr(cfg_addr), .wr_data(cfg_data),
    .inc_active(inc_active), .phase_off(phase_off)
  );

  sc_nco_accum #(.ACC_W(ACC_W)) u_accum (
    .clk(clk), .rst(rst), .inc(inc_active), .acc(acc_q)
  );

  sc_nco_phase_out #(.ACC_W(ACC_W), .OFF_W(OFF_W), .OUT_W(OUT_W)) u_out (
    .clk(clk), .rst(rst), .acc(acc_q), .off(phase_off), .phase(phase_out)
  );
endmodule

// File: rtl/sc_nco_checker.sv
module sc_nco_checker #(
  parameter int unsigned ACC_W      = 32,
  parameter int unsigned OFF_W      = 8,
  parameter int unsigned OUT_W      = 10,
  parameter int unsigned ADDR_W     = 5,
  parameter int unsigned FREQ_BASE  = 9,
  parameter int unsigned PHASE_ADDR = 13
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_we,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic [7:0]        cfg_data,
  input logic [ACC_W-1:0]  inc_active,
  input logic [ACC_W-1:0]  acc,
  input logic [OFF_W-1:0]  phase_off,
  input logic [OUT_W-1:0]  phase_out
);
  localparam int unsigned NBYTES = ACC_W / 8;
  localparam logic [ADDR_W-1:0] LO_ADDR  = ADDR_W'(FREQ_BASE);
  localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(FREQ_BASE + NBYTES - 1);
  localparam logic [ADDR_W-1:0] OFF_ADDR = ADDR_W'(PHASE_ADDR);

  logic low_wr, top_wr, off_wr, stray_wr;
  logic [ACC_W-1:0] rot_now;

  assign low_wr   = cfg_we && cfg_addr >= LO_ADDR && cfg_addr < TOP_ADDR;
  assign top_wr   = cfg_we && cfg_addr == TOP_ADDR;
  assign off_wr   = cfg_we && cfg_addr == OFF_ADDR;
  assign stray_wr = cfg_we && !low_wr && !top_wr && !off_wr;
  assign rot_now  = acc + {phase_off, {(ACC_W-OFF_W){1'b0}}};

  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> (acc == '0 && phase_out == '0));

  p_top_byte_lands_r2: assert property (@(posedge clk) disable iff (rst)
    top_wr |=> inc_active[ACC_W-1 -: 8] == $past(cfg_data));

  p_low_bytes_staged_r3: assert property (@(posedge clk) disable iff (rst)
    low_wr |=> $stable(inc_active));

  p_acc_step_r4: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> acc == $past(acc) + $past(inc_active));

  p_offset_write_r5: assert property (@(posedge clk) disable iff (rst)
    off_wr |=> phase_off == $past(cfg_data[OFF_W-1:0]));

  p_output_lag_r6: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> phase_out == $past(rot_now[ACC_W-1 -: OUT_W]));

  p_stray_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    stray_wr |=> ($stable(inc_active) && $stable(phase_off)));
endmodule

bind subcarrier_nco sc_nco_checker #(
  .ACC_W(ACC_W), .OFF_W(OFF_W), .OUT_W(OUT_W), .ADDR_W(ADDR_W),
  .FREQ_BASE(FREQ_BASE), .PHASE_ADDR(PHASE_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .cfg_data(cfg_data), .inc_active(inc_active), .acc(acc_q),
  .phase_off(phase_off), .phase_out(phase_out)
);

// File: tb/subcarrier_nco_test.sv
`timescale 1ns/1ps
module subcarrier_nco_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [4:0] cfg_addr = '0;
  logic [7:0] cfg_data = '0;
  logic [9:0] phase_out;

  int checks = 0;
  int fails = 0;
  bit cmp_on = 1'b0;
  string tag = "R1";

  // reference state, built from the requirements
  logic [23:0] m_shadow;
  logic [31:0] m_inc, m_acc;
  logic [7:0]  m_off;
  logic [9:0]  m_out;
  logic [31:0] m_rot;

  always #2 clk = ~clk;

  subcarrier_nco uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_data(cfg_data), .phase_out(phase_out)
  );

  assign m_rot = m_acc + {m_off, 24'h0};

  always @(posedge clk) begin
    if (rst) begin
      m_shadow <= 24'h000016;
      m_inc    <= 32'h0000_0016;
      m_off    <= 8'h00;
      m_acc    <= '0;
      m_out    <= '0;
    end else begin
      m_acc <= m_acc + m_inc;
      m_out <= m_rot[31:22];
      if (cfg_we) begin
        case (cfg_addr)
          5'h09: m_shadow[7:0]   <= cfg_data;
          5'h0A: m_shadow[15:8]  <= cfg_data;
          5'h0B: m_shadow[23:16] <= cfg_data;
          5'h0C: m_inc <= {cfg_data, m_shadow};
          5'h0D: m_off <= cfg_data;
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      checks++;
      if (phase_out !== m_out) begin
        fails++;
        $display("FAIL %s: phase_out=%0h expected %0h", tag, phase_out, m_out);
      end
    end
  end

  task automatic expect_eq(input string t, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", t, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic load_inc(input logic [31:0] v);
    wr(5'h09, v[7:0]);
    wr(5'h0A, v[15:8]);
    wr(5'h0B, v[23:16]);
    wr(5'h0C, v[31:24]);
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] incs [5];
    logic [9:0] p0, p1;
    incs[0] = 32'h21F0_7C1F; incs[1] = 32'h0100_0000;
    incs[2] = 32'hFFC0_0000; incs[3] = 32'h2A09_8ACB;
    incs[4] = 32'h8000_0001;

    // R1: reset state
    repeat (3) @(negedge clk);
    expect_eq("R1 reset", int'(phase_out), 0);
    rst = 1'b0;
    cmp_on = 1'b1;
    // R7: default increment and offset keep the phase near zero
    tag = "R7";
    repeat (200) @(negedge clk);
    expect_eq("R7 default", int'(phase_out), 0);

    // R2 R3 R4 R6: staged loads of several increments
    for (int i = 0; i < 5; i++) begin
      tag = "R3";
      wr(5'h09, incs[i][7:0]);
      wr(5'h0A, incs[i][15:8]);
      wr(5'h0B, incs[i][23:16]);
      repeat (20) @(negedge clk);
      tag = "R2";
      wr(5'h0C, incs[i][31:24]);
      tag = "R4";
      repeat (300) @(negedge clk);
    end

    // R3: low byte rewritten while running leaves frequency alone
    tag = "R3";
    load_inc(32'h0100_0000);
    wr(5'h0B, 8'h80);
    repeat (8) @(negedge clk);
    p0 = phase_out;
    @(negedge clk);
    expect_eq("R3 stale step", int'(phase_out - p0), 4);

    // R5: all offsets with a frozen accumulator
    do_reset();
    tag = "R5";
    load_inc(32'h0);
    do_reset();
    load_inc(32'h0);
    for (int o = 0; o < 256; o++) begin
      wr(5'h0D, 8'(o));
      @(negedge clk);
      expect_eq("R5 offset", int'(phase_out), (o * 4) % 1024);
    end
    // R5: offset wraps over a moving accumulator
    tag = "R5";
    load_inc(32'h4000_0000);
    wr(5'h0D, 8'hC0);
    repeat (50) @(negedge clk);

    // R8: stray addresses touch nothing
    tag = "R8";
    load_inc(32'h0);
    wr(5'h0D, 8'h21);
    @(negedge clk);
    for (int a = 0; a < 32; a++) begin
      if (a >= 9 && a <= 13) continue;
      wr(5'(a), 8'hFF);
      @(negedge clk);
      expect_eq("R8 stray", int'(phase_out), 8'h21 * 4);
    end

    // R9: one full 525-line video line at the NTSC increment
    tag = "R9";
    wr(5'h0D, 8'h00);
    load_inc(32'h21F0_7C1F);
    repeat (5) @(negedge clk);
    p0 = phase_out;
    repeat (1716) @(negedge clk);
    p1 = phase_out;
    checks++;
    if ((p1 - p0) != 10'd511 && (p1 - p0) != 10'd512) begin
      fails++;
      $display("FAIL R9: advance=%0d expected=511 or 512", p1 - p0);
    end

    // R1: reset mid-run clears the output
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    expect_eq("R1 mid reset", int'(phase_out), 0);
    rst = 1'b0;

    cmp_on = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule